// File: doc/BRIEF.md
# Watchdog Overflow Reset Controller

This block holds an 8-bit up-counter guarded by a small timer control register and a reset control/status register, all reached over a single-cycle register bus. In watchdog mode a wrap of the counter from its top value to zero marks a sticky overflow flag and returns the counter and its control register to their idle values. If reset generation is enabled, the overflow also starts a fixed-length internal reset pulse. In interval mode the same wrap gives only a one-cycle interval pulse, and the counter keeps running.

Two reset domains are kept apart. The external reset pin (`ext_rst_n`) clears everything, including the status register. The block's own internal reset clears only the counter and the timer control register. The overflow flag can only be cleared by a two-step handshake: software must first read the status register while the flag is set, and then write zero to the flag.

Named state machines: the flag machine has states `FLG_CLEAR`, `FLG_SET` and `FLG_ARMED`. Its transitions are CLEAR→SET on a watchdog overflow, SET→ARMED on a status read, ARMED→CLEAR on a status write with bit 7 = 0 and no overflow in the same cycle, ARMED→SET on any other status write, and ARMED→ARMED otherwise. The reset sequencer has states `RS_IDLE` and `RS_HOLD`. It goes IDLE→HOLD on a watchdog overflow with reset enable set, and HOLD→IDLE once `RST_CYCLES` cycles have elapsed.

Top module: `wdg_rst_ctrl`

## Requirements
- R1: While `ext_rst_n` is low and after it is released, the status register (address 2) reads 0x1F, the counter (address 0) and control register (address 1) read 0x00, and `int_rst_o` and `ivl_pulse_o` are 0.
- R2: The counter adds one on each clock while control bit 7 (enable) is 1 and holds otherwise. A bus write to address 0 loads the written value and takes priority over counting.
- R3: With control bit 6 = 1 (watchdog mode) and enable set, a wrap from 0xFF to 0x00 sets status bit 7 (flag) and clears the control register to 0x00, so the counter stops at 0x00.
- R4: With control bit 6 = 0 (interval mode) and enable set, a wrap raises `ivl_pulse_o` for exactly one cycle. The flag stays 0, `int_rst_o` stays 0, and counting continues.
- R5: A status read (`bus_rd` at address 2) made while the flag is 1, followed by a status write with bit 7 = 0, clears the flag.
- R6: A status write of bit 7 = 0 with no earlier read that saw the flag set leaves the flag set. Writing bit 7 = 1 never changes the flag. Any status write cancels the read-armed condition.
- R7: With status bit 6 (reset enable) = 1, a watchdog overflow drives `int_rst_o` high for exactly `RST_CYCLES` (default 16) consecutive cycles, starting in the cycle after the wrap.
- R8: With reset enable = 0, a watchdog overflow leaves `int_rst_o` at 0, while the counter and control register still return to 0x00.
- R9: Status bits 7 to 5 are unchanged by the internal reset. Bit 5 is a plain read/write bit. Bits 4 to 0 always read as 1 whatever is written.
- R10: While `int_rst_o` is high, writes to the counter and the control register are ignored and both read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| bus_addr | input | 2 | Register select: 0 counter, 1 control, 2 status, 3 unused (reads 0) |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| int_rst_o | output | 1 | Internal reset request from a watchdog overflow |
| ivl_pulse_o | output | 1 | One-cycle pulse on an interval-mode wrap |

## Verification
The hardest state to reach from the ports is `FLG_ARMED` followed by a write that does not clear the flag. To get there, the flag must first be set by a real overflow, then a strobed status read must arm it, and then a write must arrive that either sets bit 7 or follows a non-strobed look at the register. The bench reaches an overflow within a few cycles by preloading the counter just below its top value. It then runs the read/write sequences in order and checks after each write whether the flag is still set. The internal-reset window is checked at every cycle of the hold, with register writes issued in the middle of the window.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int BUS_W = 8;

    // register select codes
    typedef enum logic [1:0] {
        ADR_CNT  = 2'd0,
        ADR_CTL  = 2'd1,
        ADR_STAT = 2'd2,
        ADR_NONE = 2'd3
    } wdg_addr_e;

    typedef enum logic [1:0] {
        FLG_CLEAR = 2'd0,
        FLG_SET   = 2'd1,
        FLG_ARMED = 2'd2
    } flg_state_e;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_HOLD = 1'b1
    } rs_state_e;

    localparam int CTL_EN_BIT   = 7;
    localparam int CTL_WDT_BIT  = 6;
    localparam int ST_FLAG_BIT  = 7;
    localparam int ST_RSTE_BIT  = 6;
    localparam int ST_RSV_BIT   = 5;
    localparam int ST_FIXED_W   = 5;

endpackage

// File: rtl/wdg_count_unit.sv
module wdg_count_unit
    import wdg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             ext_rst_n,
    input  logic             clr_i,
    input  logic             cnt_wr_i,
    input  logic             ctl_wr_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             en_o,
    output logic             wdt_o,
    output logic             ovf_wdt_o,
    output logic             ovf_ivl_o,
    output logic             ivl_pulse_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             en_q, en_d;
    logic             wdt_q, wdt_d;
    logic             pulse_q;
    logic             wrap;

    // a wrap happens when the counter is at its top value, counting, and not being loaded
    always_comb begin
        wrap      = en_q && (cnt_q == CNT_TOP) && !cnt_wr_i && !clr_i;
        ovf_wdt_o = wrap && wdt_q;
        ovf_ivl_o = wrap && !wdt_q;
    end

    always_comb begin
        cnt_d = cnt_q;
        en_d  = en_q;
        wdt_d = wdt_q;
        if (clr_i || ovf_wdt_o) begin
            cnt_d = '0;
            en_d  = 1'b0;
            wdt_d = 1'b0;
        end else begin
            if (cnt_wr_i) begin
                cnt_d = wdata_i[CNT_W-1:0];
            end else if (en_q) begin
                cnt_d = cnt_q + 1'b1;
            end
            if (ctl_wr_i) begin
                en_d  = wdata_i[CTL_EN_BIT];
                wdt_d = wdata_i[CTL_WDT_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            cnt_q   <= '0;
            en_q    <= 1'b0;
            wdt_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            en_q    <= en_d;
            wdt_q   <= wdt_d;
            pulse_q <= ovf_ivl_o;
        end
    end

    assign cnt_o       = cnt_q;
    assign en_o        = en_q;
    assign wdt_o       = wdt_q;
    assign ivl_pulse_o = pulse_q;

endmodule

// File: rtl/wdg_stat_unit.sv
module wdg_stat_unit
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             ext_rst_n,
    input  logic             ovf_wdt_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [BUS_W-1:0] stat_o,
    output logic             rste_o,
    output logic             armed_o
);

    flg_state_e state_q, state_d;
    logic       rste_q, rsv_q;
    logic       flag;

    // state register: only the external pin resets this domain
    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            state_q <= FLG_CLEAR;
            rste_q  <= 1'b0;
            rsv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wr_i) begin
                rste_q <= wdata_i[ST_RSTE_BIT];
                rsv_q  <= wdata_i[ST_RSV_BIT];
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: begin
                if (ovf_wdt_i) state_d = FLG_SET;
            end
            FLG_SET: begin
                if (rd_i) state_d = FLG_ARMED;
            end
            FLG_ARMED: begin
                if (wr_i) begin
                    if (!wdata_i[ST_FLAG_BIT] && !ovf_wdt_i) state_d = FLG_CLEAR;
                    else                                     state_d = FLG_SET;
                end
            end
            default: state_d = FLG_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        flag    = 1'b0;
        armed_o = 1'b0;
        unique case (state_q)
            FLG_CLEAR: flag = 1'b0;
            FLG_SET:   flag = 1'b1;
            FLG_ARMED: begin
                flag    = 1'b1;
                armed_o = 1'b1;
            end
            default:   flag = 1'b0;
        endcase
        stat_o = {flag, rste_q, rsv_q, {ST_FIXED_W{1'b1}}};
        rste_o = rste_q;
    end

endmodule

// File: rtl/wdg_rst_seq.sv
module wdg_rst_seq
    import wdg_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic ext_rst_n,
    input  logic ovf_wdt_i,
    input  logic rste_i,
    output logic hold_o
);

    localparam int HW = $clog2(RST_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(RST_CYCLES - 1);

    rs_state_e     state_q, state_d;
    logic [HW-1:0] left_q, left_d;

    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            state_q <= RS_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            RS_IDLE: begin
                if (ovf_wdt_i && rste_i) begin
                    state_d = RS_HOLD;
                    left_d  = HOLD_LAST;
                end
            end
            RS_HOLD: begin
                if (left_q == '0) state_d = RS_IDLE;
                else              left_d  = left_q - 1'b1;
            end
            default: state_d = RS_IDLE;
        endcase
    end

    always_comb begin
        hold_o = 1'b0;
        unique case (state_q)
            RS_IDLE: hold_o = 1'b0;
            RS_HOLD: hold_o = 1'b1;
            default: hold_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdg_rst_ctrl.sv
module wdg_rst_ctrl
    import wdg_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int RST_CYCLES = 16
) (
    input  logic                  clk,
    input  logic                  ext_rst_n,
    input  logic [1:0]            bus_addr,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    output logic                  int_rst_o,
    output logic                  ivl_pulse_o
);

    logic             cnt_wr, ctl_wr, stat_wr, stat_rd;
    logic [CNT_W-1:0] cnt;
    logic             ctl_en, ctl_wdt;
    logic             ovf_wdt, ovf_ivl;
    logic [BUS_W-1:0] stat_q;
    logic             rste;
    logic             flg_armed;
    logic             hold;

    always_comb begin
        cnt_wr  = bus_wr && (bus_addr == ADR_CNT);
        ctl_wr  = bus_wr && (bus_addr == ADR_CTL);
        stat_wr = bus_wr && (bus_addr == ADR_STAT);
        stat_rd = bus_rd && (bus_addr == ADR_STAT);
    end

    wdg_count_unit #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .ext_rst_n  (ext_rst_n),
        .clr_i      (hold),
        .cnt_wr_i   (cnt_wr),
        .ctl_wr_i   (ctl_wr),
        .wdata_i    (bus_wdata),
        .cnt_o      (cnt),
        .en_o       (ctl_en),
        .wdt_o      (ctl_wdt),
        .ovf_wdt_o  (ovf_wdt),
        .ovf_ivl_o  (ovf_ivl),
        .ivl_pulse_o(ivl_pulse_o)
    );

    wdg_stat_unit u_stat (
        .clk      (clk),
        .ext_rst_n(ext_rst_n),
        .ovf_wdt_i(ovf_wdt),
        .rd_i     (stat_rd),
        .wr_i     (stat_wr),
        .wdata_i  (bus_wdata),
        .stat_o   (stat_q),
        .rste_o   (rste),
        .armed_o  (flg_armed)
    );

    wdg_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk      (clk),
        .ext_rst_n(ext_rst_n),
        .ovf_wdt_i(ovf_wdt),
        .rste_i   (rste),
        .hold_o   (hold)
    );

    assign int_rst_o = hold;

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CNT:  bus_rdata = BUS_W'(cnt);
            ADR_CTL:  bus_rdata = {ctl_en, ctl_wdt, {(BUS_W-2){1'b0}}};
            ADR_STAT: bus_rdata = stat_q;
            default:  bus_rdata = '0;
        endcase
    end

    // interval overflow is only reflected through the registered pulse
    logic unused_ok;
    assign unused_ok = ovf_ivl;

endmodule

// File: rtl/wdg_rst_ctrl_chk.sv
module wdg_rst_ctrl_chk #(
    parameter int CNT_W      = 8,
    parameter int RST_CYCLES = 16
) (
    input logic             clk,
    input logic             ext_rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic             ctl_en,
    input logic             ctl_wdt,
    input logic             cnt_wr,
    input logic             stat_wr,
    input logic [7:0]       stat_q,
    input logic             flg_armed,
    input logic             int_rst_o,
    input logic             ivl_pulse_o
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    int hi_run;
    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n)     hi_run <= 0;
        else if (int_rst_o) hi_run <= hi_run + 1;
        else                hi_run <= 0;
    end

    // R3: watchdog wrap sets the flag and stops the counter at zero
    a_r3_wdt_wrap: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (ctl_en && ctl_wdt && cnt == TOP && !cnt_wr && !int_rst_o)
        |=> (stat_q[7] && cnt == '0 && !ctl_en));

    // R4: interval wrap leaves the flag alone and gives a pulse
    a_r4_ivl_wrap: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (ctl_en && !ctl_wdt && cnt == TOP && !cnt_wr && !stat_wr && !int_rst_o)
        |=> (stat_q[7] == $past(stat_q[7]) && ivl_pulse_o));

    // R4: the interval pulse lasts one cycle
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!ext_rst_n)
        ivl_pulse_o |=> !ivl_pulse_o);

    // R6: a set flag that is not armed survives the next cycle
    a_r6_flag_kept: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (stat_q[7] && !flg_armed) |=> stat_q[7]);

    // R7: internal reset never exceeds its width
    a_r7_width_max: assert property (@(posedge clk) disable iff (!ext_rst_n)
        int_rst_o |-> (hi_run < RST_CYCLES));

    // R7: internal reset ends only after the full width
    a_r7_width_exact: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $fell(int_rst_o) |-> (hi_run == RST_CYCLES));

    // R9: status bits survive the internal reset
    a_r9_stat_kept: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (int_rst_o && !stat_wr) |=> $stable(stat_q[6:5]));

    // R9: fixed low bits
    a_r9_low_ones: assert property (@(posedge clk) disable iff (!ext_rst_n)
        stat_q[4:0] == 5'h1F);

    // R10: counter and control cleared during internal reset
    a_r10_hold_clear: assert property (@(posedge clk) disable iff (!ext_rst_n)
        int_rst_o |=> (cnt == '0 && !ctl_en));

endmodule

bind wdg_rst_ctrl wdg_rst_ctrl_chk #(
    .CNT_W     (CNT_W),
    .RST_CYCLES(RST_CYCLES)
) chk_i (
    .clk        (clk),
    .ext_rst_n  (ext_rst_n),
    .cnt        (cnt),
    .ctl_en     (ctl_en),
    .ctl_wdt    (ctl_wdt),
    .cnt_wr     (cnt_wr),
    .stat_wr    (stat_wr),
    .stat_q     (stat_q),
    .flg_armed  (flg_armed),
    .int_rst_o  (int_rst_o),
    .ivl_pulse_o(ivl_pulse_o)
);

// File: tb/wdg_rst_ctrl_tb_top.sv
module wdg_rst_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD_N     = 16;

    logic       clk = 1'b0;
    logic       ext_rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       int_rst_o;
    logic       ivl_pulse_o;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdg_rst_ctrl #(.CNT_W(8), .RST_CYCLES(HOLD_N)) dut_i (
        .clk        (clk),
        .ext_rst_n  (ext_rst_n),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .int_rst_o  (int_rst_o),
        .ivl_pulse_o(ivl_pulse_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // look at a register without a read strobe
    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick(1);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d = bus_rdata;
        tick(1);
        bus_rd   = 1'b0;
    endtask

    task automatic do_reset();
        logic [7:0] v;
        ext_rst_n = 1'b0;
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        tick(2);
        peek(2'd2, v); chk("R1 status in reset", v, 8'h1F);
        ext_rst_n = 1'b1;
        tick(1);
    endtask

    // bring the counter to a watchdog overflow; returns right after the wrap edge
    task automatic wdt_overflow();
        bus_write(2'd0, 8'hFE);
        bus_write(2'd1, 8'hC0);
        tick(2);
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        do_reset();
        peek(2'd2, v); chk("R1 status", v, 8'h1F);
        peek(2'd0, v); chk("R1 counter", v, 8'h00);
        peek(2'd1, v); chk("R1 control", v, 8'h00);
        chk("R1 int_rst", {7'd0, int_rst_o}, 8'h00);
        chk("R1 ivl_pulse", {7'd0, ivl_pulse_o}, 8'h00);
    endtask

    task automatic t_counting();
        logic [7:0] v;
        do_reset();
        bus_write(2'd0, 8'h10);
        peek(2'd0, v); chk("R2 load", v, 8'h10);
        tick(3);
        peek(2'd0, v); chk("R2 hold disabled", v, 8'h10);
        bus_write(2'd1, 8'h80);
        peek(2'd0, v); chk("R2 start", v, 8'h10);
        tick(5);
        peek(2'd0, v); chk("R2 count", v, 8'h15);
        bus_write(2'd0, 8'h40);
        peek(2'd0, v); chk("R2 load wins", v, 8'h40);
        tick(1);
        peek(2'd0, v); chk("R2 after load", v, 8'h41);
        bus_write(2'd1, 8'h00);
        tick(2);
        peek(2'd0, v); chk("R2 stopped", v, 8'h42);
    endtask

    task automatic t_wdt_reset();
        logic [7:0] v;
        do_reset();
        bus_write(2'd2, 8'h40);
        bus_write(2'd0, 8'hF0);
        bus_write(2'd1, 8'hC0);
        tick(15);
        peek(2'd0, v); chk("R3 at top", v, 8'hFF);
        chk("R7 no rst before wrap", {7'd0, int_rst_o}, 8'h00);
        tick(1);
        peek(2'd2, v); chk("R3 flag set", v, 8'hDF);
        peek(2'd0, v); chk("R3 counter zero", v, 8'h00);
        peek(2'd1, v); chk("R3 control cleared", v, 8'h00);
        for (int i = 0; i < HOLD_N; i++) begin
            chk("R7 int_rst high", {7'd0, int_rst_o}, 8'h01);
            tick(1);
        end
        chk("R7 int_rst released", {7'd0, int_rst_o}, 8'h00);
        peek(2'd2, v); chk("R9 status after hold", v, 8'hDF);
    endtask

    task automatic t_hold_ignores();
        logic [7:0] v;
        do_reset();
        bus_write(2'd2, 8'h60);
        wdt_overflow();
        chk("R10 in hold", {7'd0, int_rst_o}, 8'h01);
        bus_write(2'd0, 8'h55);
        bus_write(2'd1, 8'hC0);
        peek(2'd0, v); chk("R10 counter ignored", v, 8'h00);
        peek(2'd1, v); chk("R10 control ignored", v, 8'h00);
        peek(2'd2, v); chk("R9 status kept in hold", v, 8'hFF);
        tick(3);
        peek(2'd0, v); chk("R10 counter still zero", v, 8'h00);
    endtask

    task automatic t_no_reset();
        logic [7:0] v;
        do_reset();
        wdt_overflow();
        peek(2'd2, v); chk("R8 flag set", v, 8'h9F);
        chk("R8 no int_rst", {7'd0, int_rst_o}, 8'h00);
        peek(2'd1, v); chk("R8 control cleared", v, 8'h00);
        tick(3);
        chk("R8 still no int_rst", {7'd0, int_rst_o}, 8'h00);
        peek(2'd0, v); chk("R8 counter zero", v, 8'h00);
        bus_read(2'd2, v); chk("R5 read sees flag", v, 8'h9F);
        bus_write(2'd2, 8'h00);
        peek(2'd2, v); chk("R5 flag cleared", v, 8'h1F);
    endtask

    task automatic t_clear_rules();
        logic [7:0] v;
        do_reset();
        wdt_overflow();
        bus_write(2'd2, 8'h00);
        peek(2'd2, v); chk("R6 unarmed write 0", v, 8'h9F);
        bus_write(2'd2, 8'h80);
        peek(2'd2, v); chk("R6 write 1", v, 8'h9F);
        bus_read(2'd2, v);
        bus_write(2'd2, 8'h80);
        peek(2'd2, v); chk("R6 armed write 1", v, 8'h9F);
        bus_write(2'd2, 8'h00);
        peek(2'd2, v); chk("R6 arm cancelled", v, 8'h9F);
        bus_read(2'd2, v);
        bus_write(2'd2, 8'h20);
        peek(2'd2, v); chk("R9 rsv bit, low ones", v, 8'h3F);
    endtask

    task automatic t_interval();
        logic [7:0] v;
        do_reset();
        bus_write(2'd2, 8'h40);
        bus_write(2'd0, 8'hFD);
        bus_write(2'd1, 8'h80);
        tick(2);
        peek(2'd0, v); chk("R4 at top", v, 8'hFF);
        chk("R4 no pulse yet", {7'd0, ivl_pulse_o}, 8'h00);
        tick(1);
        chk("R4 pulse", {7'd0, ivl_pulse_o}, 8'h01);
        peek(2'd2, v); chk("R4 flag untouched", v, 8'h5F);
        chk("R4 no int_rst", {7'd0, int_rst_o}, 8'h00);
        peek(2'd1, v); chk("R4 control kept", v, 8'h80);
        tick(1);
        chk("R4 pulse ended", {7'd0, ivl_pulse_o}, 8'h00);
        peek(2'd0, v); chk("R4 keeps counting", v, 8'h01);
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_counting();
                t_wdt_reset();
                t_hold_ignores();
                t_no_reset();
                t_clear_rules();
                t_interval();
            end
            begin
                repeat (20000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule